// File: doc/BRIEF.md
# Interrupt Enable and Trap Controller

This block is the interrupt-control core of a small 8-bit processor. It takes five request sources: a non-maskable trap, three vectored restart requests (levels 7.5, 6.5 and 5.5) and a general interrupt request. It keeps the global interrupt-enable flag and the three per-restart mask bits. At each instruction boundary that the sequencer signals, it grants the highest-priority request that is allowed to run, with a one-hot acknowledge that lasts one internal cycle. Every grant clears the global enable.

The trap source needs two things at once: a rising edge captured by an edge flag, and an input that is still high when the boundary comes. When a trap is taken, the enable state from before the trap is saved. Only the next mask-read instruction returns that saved state. Every later read returns the live flag.

The mask-read value also carries the pending restart requests and a sampled serial input bit. The mask-write instruction can load the restart masks and the serial output bit, each under its own load-enable bit. The external clock runs at twice the internal rate. All instruction-level state changes on an internal tick, which is derived by dividing that clock by two.

Top module: `irq_ctrl_core`

## Requirements
- R1: After reset the global enable is clear, all three restart masks are set, the serial output is 0 and the acknowledge is 0, so `rim_data` reads 8'h07 with all inputs low.
- R2: `core_tick` is high for exactly one `clk_in` cycle in every two, and never in two consecutive cycles. Instruction-level state changes only on a rising clock edge where `core_tick` is high.
- R3: A trap is granted only when a rising edge of `trap_in` has been captured since the last trap acknowledge and `trap_in` is still high at the boundary. A level held high since reset, or a pulse that has already dropped, yields no grant.
- R4: A trap is granted regardless of the global enable and the masks. Its acknowledge clears the captured edge, so a `trap_in` held high gives no second grant.
- R5: `ack` is one-hot or zero, with bit 0 for trap, bit 1 for restart 7.5, bit 2 for restart 6.5, bit 3 for restart 5.5 and bit 4 for the general request. Only the highest-priority eligible source is acknowledged, in that order from bit 0 down. The acknowledge appears on the tick edge where `boundary` is high and lasts until the next tick edge.
- R6: Any grant clears the global enable, and a grant overrides an enable command on the same tick. `ei_cmd` sets the enable and `di_cmd` clears it. The enable stays clear until `ei_cmd` is applied.
- R7: Restarts need the enable set and their own mask bit clear: write bit 0 masks 5.5, bit 1 masks 6.5, bit 2 masks 7.5. The general request needs only the enable. The masks load from write bits 2:0 only when write bit 3 is 1.
- R8: Restart 7.5 is latched on its rising edge and stays pending until it is acknowledged. Restarts 6.5 and 5.5 and the general request are level-sensitive and vanish when dropped.
- R9: The first mask read after a trap grant returns, in `rim_data` bit 3, the enable state from before the trap. Every later read returns the current enable.
- R10: A mask read after a restart or general-request grant shows bit 3 as 0.
- R11: `rim_data` bit 7 is `serial_in` as sampled on the last tick. A mask write with bit 4 set loads `serial_out` from bit 5. With bit 4 clear, `serial_out` is unchanged.
- R12: `rim_data` bits 4, 5 and 6 show the pending 5.5, 6.5 and 7.5 requests, whatever the masks and the enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | External clock, twice the internal rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_in | input | 1 | Non-maskable trap request |
| rst75_in | input | 1 | Restart 7.5 request, edge-latched |
| rst65_in | input | 1 | Restart 6.5 request, level |
| rst55_in | input | 1 | Restart 5.5 request, level |
| intr_in | input | 1 | General interrupt request, level |
| boundary | input | 1 | Instruction boundary; grant taken on this tick |
| ei_cmd | input | 1 | Enable-interrupts command |
| di_cmd | input | 1 | Disable-interrupts command |
| mask_rd | input | 1 | Mask-read instruction executed on this tick |
| mask_wr | input | 1 | Mask-write instruction executed on this tick |
| mask_wdata | input | 6 | Mask-write operand |
| serial_in | input | 1 | Serial input bit |
| core_tick | output | 1 | Internal clock enable |
| ack | output | 5 | One-hot acknowledge |
| rim_data | output | 8 | Mask-read value |
| serial_out | output | 1 | Serial output bit |

## Verification
The hardest situation to reach from the ports is the saved-enable read after a trap. It needs a fresh trap edge while the enable is set, a boundary while the trap line is still high, and then two reads in a row with different expected bit 3. The stimulus reaches it with a sweep over every mask value and every combination of the five requests, all taken with the enable set. After each grant the bench makes two mask reads and predicts both from the granted source. Before the sweep, directed sequences cover a trap line held high through reset, a trap pulse that has dropped before the boundary, and a latched 7.5 request that arrives while interrupts are disabled.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int SRC_N = 5;
  localparam int MSK_N = 3;
  localparam int WR_W  = 6;
  localparam int RD_W  = 8;

  // source index equals priority rank (0 highest)
  typedef enum logic [2:0] {
    SRC_TRAP = 3'd0,
    SRC_R75  = 3'd1,
    SRC_R65  = 3'd2,
    SRC_R55  = 3'd3,
    SRC_INTR = 3'd4
  } src_e;

  // mask bit positions
  localparam int MB_R55 = 0;
  localparam int MB_R65 = 1;
  localparam int MB_R75 = 2;

  // write operand fields
  localparam int WB_MLOAD = 3;
  localparam int WB_SLOAD = 4;
  localparam int WB_SVAL  = 5;

  // read value fields
  localparam int RB_IE   = 3;
  localparam int RB_P55  = 4;
  localparam int RB_P65  = 5;
  localparam int RB_P75  = 6;
  localparam int RB_SIN  = 7;
endpackage

// File: rtl/irq_reset_sync.sv
module irq_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_n;

  always_comb begin
    sync_n = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= sync_n;
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/irq_clk_div.sv
module irq_clk_div #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  generate
    if (DIV > 1) begin : g_div
      localparam int CW = $clog2(DIV);
      logic [CW-1:0] cnt_q;
      logic [CW-1:0] cnt_n;
      logic          wrap;

      always_comb begin
        wrap  = (cnt_q == CW'(DIV - 1));
        cnt_n = wrap ? '0 : cnt_q + CW'(1);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_n;
      end

      assign tick = wrap;
    end else begin : g_pass
      assign tick = rst_n;
    end
  endgenerate
endmodule

// File: rtl/irq_edge_latch.sv
module irq_edge_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic sig,
  input  logic clr,
  output logic flag
);
  logic prev_q, prev_n;
  logic flag_q, flag_n;

  always_comb begin
    prev_n = sig;
    // a new edge wins over a clear in the same cycle
    flag_n = (sig & ~prev_q) | (flag_q & ~clr);
  end

  // previous sample resets high: a level held through reset is no edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      flag_q <= 1'b0;
    end else begin
      prev_q <= prev_n;
      flag_q <= flag_n;
    end
  end

  assign flag = flag_q;
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb #(
  parameter int N = 5
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_rank
      if (i == 0) begin : g_top
        assign gnt[i] = req[i];
      end else begin : g_low
        assign gnt[i] = req[i] & ~(|req[i-1:0]);
      end
    end
  endgenerate
endmodule

// File: rtl/irq_ctrl_core.sv
module irq_ctrl_core
  import irq_pkg::*;
#(
  parameter int DIV        = 2,
  parameter int RST_STAGES = 2
) (
  input  logic              clk_in,
  input  logic              rst_n,
  input  logic              trap_in,
  input  logic              rst75_in,
  input  logic              rst65_in,
  input  logic              rst55_in,
  input  logic              intr_in,
  input  logic              boundary,
  input  logic              ei_cmd,
  input  logic              di_cmd,
  input  logic              mask_rd,
  input  logic              mask_wr,
  input  logic [WR_W-1:0]   mask_wdata,
  input  logic              serial_in,
  output logic              core_tick,
  output logic [SRC_N-1:0]  ack,
  output logic [RD_W-1:0]   rim_data,
  output logic              serial_out
);
  logic rst_sync_n;
  logic tick;

  irq_reset_sync #(.STAGES(RST_STAGES)) u_rsync (
    .clk(clk_in), .rst_n_in(rst_n), .rst_n_out(rst_sync_n)
  );

  irq_clk_div #(.DIV(DIV)) u_div (
    .clk(clk_in), .rst_n(rst_sync_n), .tick(tick)
  );

  // state
  logic             ie_q, ie_n;
  logic             saved_q, saved_n;
  logic             oneshot_q, oneshot_n;
  logic [MSK_N-1:0] mask_q, mask_n;
  logic             sout_q, sout_n;
  logic             sin_q, sin_n;
  logic [SRC_N-1:0] ack_q, ack_n;

  logic trap_flag, r75_flag;
  logic [SRC_N-1:0] req, elig, gnt, gnt_eff;
  logic take;

  irq_edge_latch u_trap_edge (
    .clk(clk_in), .rst_n(rst_sync_n), .sig(trap_in),
    .clr(gnt_eff[SRC_TRAP]), .flag(trap_flag)
  );

  irq_edge_latch u_r75_edge (
    .clk(clk_in), .rst_n(rst_sync_n), .sig(rst75_in),
    .clr(gnt_eff[SRC_R75]), .flag(r75_flag)
  );

  always_comb begin
    req           = '0;
    req[SRC_TRAP] = trap_flag & trap_in;
    req[SRC_R75]  = r75_flag;
    req[SRC_R65]  = rst65_in;
    req[SRC_R55]  = rst55_in;
    req[SRC_INTR] = intr_in;

    elig           = '0;
    elig[SRC_TRAP] = req[SRC_TRAP];
    elig[SRC_R75]  = req[SRC_R75] & ie_q & ~mask_q[MB_R75];
    elig[SRC_R65]  = req[SRC_R65] & ie_q & ~mask_q[MB_R65];
    elig[SRC_R55]  = req[SRC_R55] & ie_q & ~mask_q[MB_R55];
    elig[SRC_INTR] = req[SRC_INTR] & ie_q;
  end

  irq_prio_arb #(.N(SRC_N)) u_arb (.req(elig), .gnt(gnt));

  always_comb begin
    take    = tick & boundary;
    gnt_eff = take ? gnt : '0;
  end

  // next state
  always_comb begin
    ack_n     = ack_q;
    ie_n      = ie_q;
    saved_n   = saved_q;
    oneshot_n = oneshot_q;
    mask_n    = mask_q;
    sout_n    = sout_q;
    sin_n     = sin_q;

    if (tick) begin
      ack_n = gnt_eff;
      sin_n = serial_in;

      if (|gnt_eff)    ie_n = 1'b0;
      else if (di_cmd) ie_n = 1'b0;
      else if (ei_cmd) ie_n = 1'b1;

      if (gnt_eff[SRC_TRAP]) begin
        saved_n   = ie_q;
        oneshot_n = 1'b1;
      end else if (mask_rd) begin
        oneshot_n = 1'b0;
      end

      if (mask_wr && mask_wdata[WB_MLOAD]) mask_n = mask_wdata[MSK_N-1:0];
      if (mask_wr && mask_wdata[WB_SLOAD]) sout_n = mask_wdata[WB_SVAL];
    end
  end

  // registers
  always_ff @(posedge clk_in or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ack_q     <= '0;
      ie_q      <= 1'b0;
      saved_q   <= 1'b0;
      oneshot_q <= 1'b0;
      mask_q    <= '1;
      sout_q    <= 1'b0;
      sin_q     <= 1'b0;
    end else begin
      ack_q     <= ack_n;
      ie_q      <= ie_n;
      saved_q   <= saved_n;
      oneshot_q <= oneshot_n;
      mask_q    <= mask_n;
      sout_q    <= sout_n;
      sin_q     <= sin_n;
    end
  end

  always_comb begin
    rim_data              = '0;
    rim_data[MSK_N-1:0]   = mask_q;
    rim_data[RB_IE]       = oneshot_q ? saved_q : ie_q;
    rim_data[RB_P55]      = rst55_in;
    rim_data[RB_P65]      = rst65_in;
    rim_data[RB_P75]      = r75_flag;
    rim_data[RB_SIN]      = sin_q;
  end

  assign core_tick  = tick;
  assign ack        = ack_q;
  assign serial_out = sout_q;
endmodule

// File: rtl/irq_ctrl_checker.sv
module irq_ctrl_checker #(
  parameter int DIV = 2
) (
  input logic       clk,
  input logic       rst_sync_n,
  input logic       core_tick,
  input logic       trap_in,
  input logic [4:0] ack,
  input logic       ie_q,
  input logic [2:0] mask_q,
  input logic       oneshot_q,
  input logic       mask_rd,
  input logic       mask_wr,
  input logic [5:0] mask_wdata,
  input logic       serial_out
);
  assert_ack_onehot_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0(ack));

  assert_grant_clears_ie_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (|ack) |-> !ie_q);

  assert_trap_level_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(ack[0]) |-> $past(trap_in));

  assert_r75_gated_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(ack[1]) |-> $past(ie_q && !mask_q[2]));

  assert_oneshot_read_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(oneshot_q) |-> $past(core_tick && mask_rd));

  assert_serial_hold_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(core_tick && mask_wr && mask_wdata[4]) |=> $stable(serial_out));

  generate
    if (DIV > 1) begin : g_tick
      assert_tick_alternates_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
        core_tick |=> !core_tick);
    end
  endgenerate
endmodule

bind irq_ctrl_core irq_ctrl_checker #(.DIV(DIV)) u_chk (
  .clk(clk_in), .rst_sync_n(rst_sync_n), .core_tick(core_tick),
  .trap_in(trap_in), .ack(ack), .ie_q(ie_q), .mask_q(mask_q),
  .oneshot_q(oneshot_q), .mask_rd(mask_rd), .mask_wr(mask_wr),
  .mask_wdata(mask_wdata), .serial_out(serial_out)
);

// File: tb/tb_irq_ctrl_core.sv
module tb_irq_ctrl_core;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       trap_in, rst75_in, rst65_in, rst55_in, intr_in;
  logic       boundary, ei_cmd, di_cmd, mask_rd, mask_wr;
  logic [5:0] mask_wdata;
  logic       serial_in;
  logic       core_tick;
  logic [4:0] ack;
  logic [7:0] rim_data;
  logic       serial_out;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  irq_ctrl_core dut (
    .clk_in(clk), .rst_n(rst_n), .trap_in(trap_in), .rst75_in(rst75_in),
    .rst65_in(rst65_in), .rst55_in(rst55_in), .intr_in(intr_in),
    .boundary(boundary), .ei_cmd(ei_cmd), .di_cmd(di_cmd),
    .mask_rd(mask_rd), .mask_wr(mask_wr), .mask_wdata(mask_wdata),
    .serial_in(serial_in), .core_tick(core_tick), .ack(ack),
    .rim_data(rim_data), .serial_out(serial_out)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic to_tick();
    @(negedge clk);
    while (!core_tick) @(negedge clk);
  endtask

  task automatic commit();
    to_tick();
    @(negedge clk);
  endtask

  task automatic do_ei();
    ei_cmd = 1'b1; commit(); ei_cmd = 1'b0;
  endtask

  task automatic do_di();
    di_cmd = 1'b1; commit(); di_cmd = 1'b0;
  endtask

  task automatic do_boundary(output logic [4:0] a);
    boundary = 1'b1; commit(); boundary = 1'b0; a = ack;
  endtask

  task automatic do_read(output logic [7:0] v);
    mask_rd = 1'b1; to_tick(); v = rim_data; @(negedge clk); mask_rd = 1'b0;
  endtask

  task automatic do_write(input logic [5:0] w);
    mask_wr = 1'b1; mask_wdata = w; commit(); mask_wr = 1'b0; mask_wdata = '0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [4:0] lowest(input logic [4:0] e);
    for (int i = 0; i < 5; i++) if (e[i]) return 5'(1 << i);
    return 5'd0;
  endfunction

  initial begin
    int cnt;
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [4:0] a;
    logic [7:0] v;
    int tcnt;
    bit consec;
    bit prev;

    rst_n = 1'b0; trap_in = 1'b1; rst75_in = 0; rst65_in = 0; rst55_in = 0;
    intr_in = 0; boundary = 0; ei_cmd = 0; di_cmd = 0; mask_rd = 0;
    mask_wr = 0; mask_wdata = '0; serial_in = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // R1 reset state
    chk("R1 ack", {3'b0, ack}, 8'h00);
    chk("R1 serial_out", {7'b0, serial_out}, 8'h00);
    chk("R1 rim", rim_data, 8'h07);

    // R2 tick cadence
    tcnt = 0; consec = 0; prev = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (core_tick) tcnt++;
      if (core_tick && prev) consec = 1;
      prev = core_tick;
    end
    chk("R2 tick count", 8'(tcnt), 8'd10);
    chk("R2 no consecutive", {7'b0, consec}, 8'h00);

    // R3 level held since reset is not an edge
    do_boundary(a);
    chk("R3 held level", {3'b0, a}, 8'h00);
    trap_in = 0; settle();
    // R3 pulse dropped before the boundary
    trap_in = 1; repeat (2) @(negedge clk); trap_in = 0; settle();
    do_boundary(a);
    chk("R3 dropped pulse", {3'b0, a}, 8'h00);
    // R4 edge plus level with enable clear and all masks set
    trap_in = 1; settle();
    do_boundary(a);
    chk("R4 trap while disabled", {3'b0, a}, 8'h01);
    do_boundary(a);
    chk("R4 no second grant", {3'b0, a}, 8'h00);
    do_read(v);
    chk("R9 saved clear", {7'b0, v[3]}, 8'h00);
    trap_in = 0; settle();

    // R9 trap with enable set
    do_ei();
    trap_in = 1; settle();
    do_boundary(a);
    chk("R9 trap grant", {3'b0, a}, 8'h01);
    do_read(v);
    chk("R9 first read saved", {7'b0, v[3]}, 8'h01);
    do_read(v);
    chk("R9 second read live", {7'b0, v[3]}, 8'h00);
    trap_in = 0; settle();

    // R6 enable commands
    do_ei(); do_read(v); chk("R6 ei sets", {7'b0, v[3]}, 8'h01);
    do_di(); do_read(v); chk("R6 di clears", {7'b0, v[3]}, 8'h00);
    do_ei();
    intr_in = 1; settle();
    do_boundary(a);
    chk("R6 intr grant", {3'b0, a}, 8'h10);
    do_read(v);
    chk("R10 read after intr", {7'b0, v[3]}, 8'h00);
    do_boundary(a);
    chk("R6 stays clear", {3'b0, a}, 8'h00);
    intr_in = 0; settle();

    // R6 grant overrides ei on the same tick
    do_ei();
    intr_in = 1; settle();
    boundary = 1; ei_cmd = 1; commit(); boundary = 0; ei_cmd = 0;
    chk("R6 grant with ei", {3'b0, ack}, 8'h10);
    do_read(v);
    chk("R6 grant beats ei", {7'b0, v[3]}, 8'h00);
    intr_in = 0; settle();

    // R8 edge-latched 7.5 while disabled
    do_write(6'b001000);
    rst75_in = 1; repeat (2) @(negedge clk); rst75_in = 0; settle();
    do_read(v);
    chk("R12 r75 pending", {7'b0, v[6]}, 8'h01);
    do_boundary(a);
    chk("R8 r75 held while disabled", {3'b0, a}, 8'h00);
    do_ei();
    do_boundary(a);
    chk("R8 r75 granted later", {3'b0, a}, 8'h02);
    do_read(v);
    chk("R8 r75 cleared", {7'b0, v[6]}, 8'h00);
    // R8 level source dropped
    do_ei();
    rst65_in = 1; settle(); rst65_in = 0; settle();
    do_boundary(a);
    chk("R8 dropped level", {3'b0, a}, 8'h00);

    // R12 pending bits of level sources
    rst55_in = 1; settle();
    do_read(v);
    chk("R12 r55 pending", {6'b0, v[5:4]}, 8'h01);
    rst55_in = 0; settle();

    // R11 serial bits
    serial_in = 1; commit(); do_read(v);
    chk("R11 sin high", {7'b0, v[7]}, 8'h01);
    serial_in = 0; commit(); do_read(v);
    chk("R11 sin low", {7'b0, v[7]}, 8'h00);
    do_write(6'b110101);
    chk("R11 sout loaded", {7'b0, serial_out}, 8'h01);
    do_read(v);
    chk("R7 masks kept without load", {5'b0, v[2:0]}, 8'h00);
    do_write(6'b001000);
    chk("R11 sout kept", {7'b0, serial_out}, 8'h01);

    // R5 R7 R10 sweep over masks and request sets
    for (int m = 0; m < 8; m++) begin
      for (int r = 0; r < 32; r++) begin
        logic [4:0] e, exp;
        do_write({3'b001, 3'(m)});
        do_ei();
        rst65_in = r[2]; rst55_in = r[3]; intr_in = r[4];
        if (r[1]) begin rst75_in = 1; repeat (2) @(negedge clk); rst75_in = 0; end
        if (r[0]) trap_in = 1;
        settle();
        e = {r[4], r[3] & ~m[0], r[2] & ~m[1], r[1] & ~m[2], r[0]};
        exp = lowest(e);
        do_boundary(a);
        chk("R5 R7 sweep grant", {3'b0, a}, {3'b0, exp});
        do_read(v);
        chk("R10 sweep first read", {7'b0, v[3]}, {7'b0, (exp == 5'd0) || exp[0]});
        do_read(v);
        chk("R9 sweep second read", {7'b0, v[3]}, {7'b0, exp == 5'd0});
        trap_in = 0; rst65_in = 0; rst55_in = 0; intr_in = 0;
        do_write(6'b001000);
        for (int k = 0; k < 3; k++) begin
          do_ei();
          do_boundary(a);
        end
      end
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule